// File: doc/BRIEF.md
# Windowed Matrix Initialization and Transpose Engine

This engine fills a rectangular region of a window-organized matrix buffer. The buffer holds a matrix as a grid of square windows, and every buffer address holds one whole window of `WIN`×`WIN` 32-bit lanes. The engine takes one command at a time. A command names one of four operations: copy, transpose, constant fill or diagonal fill. It also gives a source window coordinate, a destination window coordinate, the region height and width in windows (each minus one) and a fill value. The engine then walks the region one window per cycle and writes a whole window on every write cycle.

Copy and transpose read through a window read port with a fixed latency of `RD_LAT` cycles. Transpose moves source window (i, j) to destination window (j, i) and also swaps rows and columns inside each window. Constant fill and diagonal fill make their data internally and never read. A host or sequencer starts the engine with a one-cycle command strobe. It watches `busy` and waits for the `done` pulse.

Top module: `mxi_engine`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `rd_en` and `wr_en` are all low.
- R2: A command is taken only on a clock edge where `cmd_valid` is high and `busy` is low. A command presented while `busy` is high is ignored and leaves the running sequence unchanged.
- R3: Windows are visited row by row: column index j advances fastest and row index i advances slowest. There is one window per cycle, in cycles 1..N after the accepting edge, where N = (rows_m1+1)*(cols_m1+1). For copy and transpose, `rd_en` is high in those cycles and `rd_addr` = (src_row+i)*GRID_COLS + (src_col+j).
- R4: Copy (op code 0) writes each window unchanged to address (dst_row+i)*GRID_COLS + (dst_col+j).
- R5: Transpose (op code 1) writes window (i, j) to address (dst_row+j)*GRID_COLS + (dst_col+i). Output lane r*WIN+c takes input lane c*WIN+r, where lane L occupies data bits [L*32 +: 32].
- R6: Constant fill (op code 2) writes the fill value to every lane of every destination window and never raises `rd_en`.
- R7: Diagonal fill (op code 3) writes the fill value to lane r*WIN+c of window (i, j) when i == j and r == c, and writes zero to every other lane. It never raises `rd_en`.
- R8: The k-th write (k from 0) is issued in cycle 1+k+RD_LAT after the accepting edge, for every operation.
- R9: `busy` is high from the cycle after acceptance through the cycle of the last write. `done` is high for exactly the following cycle, and `busy` is low in that cycle.

Ports use the defaults GRID_ROWS = GRID_COLS = 8, WIN = 8, LANE_W = 32, with AW = log2(GRID_ROWS*GRID_COLS), RW = log2(GRID_ROWS), CW = log2(GRID_COLS) and DW = WIN*WIN*LANE_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 copy, 1 transpose, 2 fill, 3 diagonal |
| cmd_src_row | input | RW | Source region top window row |
| cmd_src_col | input | CW | Source region left window column |
| cmd_dst_row | input | RW | Destination region top window row |
| cmd_dst_col | input | CW | Destination region left window column |
| cmd_rows_m1 | input | RW | Region height in windows minus one |
| cmd_cols_m1 | input | CW | Region width in windows minus one |
| cmd_fill | input | LANE_W | Fill value for fill and diagonal |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_en | output | 1 | Window read request |
| rd_addr | output | AW | Window read address |
| rd_data | input | DW | Window read data, valid RD_LAT cycles after request |
| wr_en | output | 1 | Window write strobe |
| wr_addr | output | AW | Window write address |
| wr_data | output | DW | Window write data |

## Verification
Each result is due at a fixed cycle counted from the accepting edge. Read requests appear in cycles 1..N. The k-th write appears in cycle 1+k+RD_LAT, `done` appears in cycle N+RD_LAT+1, and `busy` goes high in cycle 1 and low in the `done` cycle. The bench builds the expected read and write sequences from the requirements and a snapshot of its own buffer model. It then compares every output at each negative clock edge of the run, one cycle past `done`. In this way a write that comes one cycle early or late, or that goes to the wrong address, is flagged in the cycle where it happens. The bench runs with a read latency of two, so the trailing delay line is tested with more than one stage.

// File: rtl/mxi_pkg.sv
// Shared types for the windowed matrix init/transpose engine.
package mxi_pkg;
    // Operation codes; the encoding is visible at the command port.
    typedef enum logic [1:0] {
        OP_COPY  = 2'd0,
        OP_XPOSE = 2'd1,
        OP_FILL  = 2'd2,
        OP_DIAG  = 2'd3
    } mxi_op_e;
endpackage

// File: rtl/mxi_delay.sv
// Fixed-depth register delay line.
// Assumes: DEPTH >= 0; with DEPTH == 0 the output follows the input.
module mxi_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign dout = din;
        end else begin : g_regs
            logic [W-1:0] stg [DEPTH];
            // Shift the payload one stage per cycle; cleared in reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
                end else begin
                    stg[0] <= din;
                    for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
                end
            end
            assign dout = stg[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/mxi_walker.sv
// Region address generator: holds the accepted command and scans the
// region's windows row by row, one per cycle, producing the read address and
// the matching destination address.
// Assumes: the command region fits in the grid; start only when idle.
module mxi_walker
    import mxi_pkg::*;
#(
    parameter int GRID_ROWS = 8,
    parameter int GRID_COLS = 8,
    parameter int LANE_W    = 32,
    localparam int RW = $clog2(GRID_ROWS),
    localparam int CW = $clog2(GRID_COLS),
    localparam int AW = $clog2(GRID_ROWS * GRID_COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mxi_op_e           op_in,
    input  logic [RW-1:0]     src_row_in,
    input  logic [CW-1:0]     src_col_in,
    input  logic [RW-1:0]     dst_row_in,
    input  logic [CW-1:0]     dst_col_in,
    input  logic [RW-1:0]     rows_m1_in,
    input  logic [CW-1:0]     cols_m1_in,
    input  logic [LANE_W-1:0] fill_in,
    output logic              active,
    output logic              last,
    output logic              on_diag,
    output mxi_op_e           op_q,
    output logic [LANE_W-1:0] fill_q,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    output logic [AW-1:0]     dst_addr
);
    logic [RW-1:0] src_row, dst_row, rows_m1, i_q;
    logic [CW-1:0] src_col, dst_col, cols_m1, j_q;
    logic          row_end, col_end;

    // Latch the command fields when a new command starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_COPY;
            fill_q  <= '0;
            src_row <= '0;
            src_col <= '0;
            dst_row <= '0;
            dst_col <= '0;
            rows_m1 <= '0;
            cols_m1 <= '0;
        end else if (start) begin
            op_q    <= op_in;
            fill_q  <= fill_in;
            src_row <= src_row_in;
            src_col <= src_col_in;
            dst_row <= dst_row_in;
            dst_col <= dst_col_in;
            rows_m1 <= rows_m1_in;
            cols_m1 <= cols_m1_in;
        end
    end

    assign col_end = (j_q == cols_m1);
    assign row_end = (i_q == rows_m1);

    // Step the window indices, column fastest, and stop after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            i_q    <= '0;
            j_q    <= '0;
        end else if (start) begin
            active <= 1'b1;
            i_q    <= '0;
            j_q    <= '0;
        end else if (active) begin
            if (col_end) begin
                j_q <= '0;
                if (row_end) active <= 1'b0;
                else         i_q    <= i_q + 1'b1;
            end else begin
                j_q <= j_q + 1'b1;
            end
        end
    end

    // Form the linear addresses and the per-window flags.
    always_comb begin
        last    = active && col_end && row_end;
        on_diag = (AW'(i_q) == AW'(j_q));
        rd_en   = active && (op_q == OP_COPY || op_q == OP_XPOSE);
        rd_addr = (AW'(src_row) + AW'(i_q)) * AW'(GRID_COLS)
                + AW'(src_col) + AW'(j_q);
        if (op_q == OP_XPOSE)
            dst_addr = (AW'(dst_row) + AW'(j_q)) * AW'(GRID_COLS)
                     + AW'(dst_col) + AW'(i_q);
        else
            dst_addr = (AW'(dst_row) + AW'(i_q)) * AW'(GRID_COLS)
                     + AW'(dst_col) + AW'(j_q);
    end

    // R2
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);
    // R3
    scan_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last && !start) |=> active);
endmodule

// File: rtl/mxi_window_mux.sv
// Window datapath: selects per lane between pass-through, in-window
// transpose, constant fill and diagonal pattern.
// Assumes: square windows; lane L sits at bits [L*LANE_W +: LANE_W].
module mxi_window_mux
    import mxi_pkg::*;
#(
    parameter int WIN    = 8,
    parameter int LANE_W = 32,
    localparam int DW = WIN * WIN * LANE_W
) (
    input  mxi_op_e           op,
    input  logic              win_on_diag,
    input  logic [LANE_W-1:0] fill,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     dout
);
    generate
        for (genvar r = 0; r < WIN; r++) begin : g_row
            for (genvar c = 0; c < WIN; c++) begin : g_col
                localparam int OUT_L = r * WIN + c;
                localparam int SWP_L = c * WIN + r;
                // Choose this lane's value by operation.
                always_comb begin
                    unique case (op)
                        OP_COPY:  dout[OUT_L*LANE_W +: LANE_W] = din[OUT_L*LANE_W +: LANE_W];
                        OP_XPOSE: dout[OUT_L*LANE_W +: LANE_W] = din[SWP_L*LANE_W +: LANE_W];
                        OP_FILL:  dout[OUT_L*LANE_W +: LANE_W] = fill;
                        default:  dout[OUT_L*LANE_W +: LANE_W] =
                                      (win_on_diag && (r == c)) ? fill : '0;
                    endcase
                end
            end
        end
    endgenerate
endmodule

// File: rtl/mxi_engine.sv
// Windowed matrix init/transpose engine top. Accepts one command while idle,
// scans the region one window per cycle, delays write-side control by the
// read latency, and pulses done one cycle after the last write.
// Assumes: the read port returns data exactly RD_LAT cycles after rd_en;
// source and destination regions do not collide within the pipeline window.
module mxi_engine
    import mxi_pkg::*;
#(
    parameter int GRID_ROWS = 8,
    parameter int GRID_COLS = 8,
    parameter int WIN       = 8,
    parameter int LANE_W    = 32,
    parameter int RD_LAT    = 1,
    localparam int RW = $clog2(GRID_ROWS),
    localparam int CW = $clog2(GRID_COLS),
    localparam int AW = $clog2(GRID_ROWS * GRID_COLS),
    localparam int DW = WIN * WIN * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [RW-1:0]     cmd_src_row,
    input  logic [CW-1:0]     cmd_src_col,
    input  logic [RW-1:0]     cmd_dst_row,
    input  logic [CW-1:0]     cmd_dst_col,
    input  logic [RW-1:0]     cmd_rows_m1,
    input  logic [CW-1:0]     cmd_cols_m1,
    input  logic [LANE_W-1:0] cmd_fill,
    output logic              busy,
    output logic              done,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    input  logic [DW-1:0]     rd_data,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data
);
    localparam int PW = AW + 3;

    logic              accept;
    logic              w_active, w_last, w_diag;
    mxi_op_e           op_q;
    logic [LANE_W-1:0] fill_q;
    logic [AW-1:0]     w_dst;
    logic [PW-1:0]     pipe_in, pipe_out;
    logic              o_last, o_diag;

    assign accept = cmd_valid && !busy;

    mxi_walker #(
        .GRID_ROWS(GRID_ROWS), .GRID_COLS(GRID_COLS), .LANE_W(LANE_W)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .start(accept),
        .op_in(mxi_op_e'(cmd_op)),
        .src_row_in(cmd_src_row), .src_col_in(cmd_src_col),
        .dst_row_in(cmd_dst_row), .dst_col_in(cmd_dst_col),
        .rows_m1_in(cmd_rows_m1), .cols_m1_in(cmd_cols_m1),
        .fill_in(cmd_fill),
        .active(w_active), .last(w_last), .on_diag(w_diag),
        .op_q(op_q), .fill_q(fill_q),
        .rd_en(rd_en), .rd_addr(rd_addr), .dst_addr(w_dst)
    );

    assign pipe_in = {w_active, w_last, w_diag, w_dst};

    mxi_delay #(.W(PW), .DEPTH(RD_LAT)) u_dly (
        .clk(clk), .rst_n(rst_n), .din(pipe_in), .dout(pipe_out)
    );

    assign {wr_en, o_last, o_diag, wr_addr} = pipe_out;

    mxi_window_mux #(.WIN(WIN), .LANE_W(LANE_W)) u_mux (
        .op(op_q), .win_on_diag(o_diag), .fill(fill_q),
        .din(rd_data), .dout(wr_data)
    );

    // Track command occupancy and raise done after the final write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= wr_en && o_last;
            if (accept)                busy <= 1'b1;
            else if (wr_en && o_last)  busy <= 1'b0;
        end
    end

    // R9
    wr_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);
    // R9
    rd_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R8
    done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_en));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/sim_mxi_engine.sv
`timescale 1ns/100ps
module sim_mxi_engine;
    localparam int GR = 4, GC = 4, WN = 4, LW = 32, RL = 2;
    localparam int AW = 4, DW = WN * WN * LW, NW = GR * GC;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [1:0] cmd_src_row = '0, cmd_dst_row = '0, cmd_rows_m1 = '0;
    logic [1:0] cmd_src_col = '0, cmd_dst_col = '0, cmd_cols_m1 = '0;
    logic [LW-1:0] cmd_fill = '0;
    logic busy, done, rd_en, wr_en;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data, p1;
    logic [DW-1:0] mem [NW];

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    mxi_engine #(.GRID_ROWS(GR), .GRID_COLS(GC), .WIN(WN), .LANE_W(LW), .RD_LAT(RL)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_src_row(cmd_src_row), .cmd_src_col(cmd_src_col),
        .cmd_dst_row(cmd_dst_row), .cmd_dst_col(cmd_dst_col),
        .cmd_rows_m1(cmd_rows_m1), .cmd_cols_m1(cmd_cols_m1), .cmd_fill(cmd_fill),
        .busy(busy), .done(done), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

    // Buffer model: two-cycle read latency, write on the edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < NW; a++)
                for (int l = 0; l < WN*WN; l++)
                    mem[a][l*LW +: LW] <= 32'hA000_0000 + a*256 + l;
            p1 <= '0;
            rd_data <= '0;
        end else begin
            p1 <= mem[rd_addr];
            rd_data <= p1;
            if (wr_en) mem[wr_addr] <= wr_data;
        end
    end

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one command and compare every output cycle by cycle.
    task automatic run_cmd(input int op, input int sr, input int sc, input int dr, input int dc,
                           input int rm1, input int cm1, input logic [LW-1:0] fill,
                           input bit hold_other);
        int ex_rd[$];
        int ex_wa[$];
        logic [DW-1:0] ex_wd[$];
        int n;
        bit reads;
        n = (rm1 + 1) * (cm1 + 1);
        reads = (op == 0 || op == 1);
        for (int i = 0; i <= rm1; i++) begin
            for (int j = 0; j <= cm1; j++) begin
                logic [DW-1:0] src, d;
                src = mem[(sr+i)*GC + sc + j];
                ex_rd.push_back((sr+i)*GC + sc + j);
                if (op == 1) ex_wa.push_back((dr+j)*GC + dc + i);
                else         ex_wa.push_back((dr+i)*GC + dc + j);
                for (int r = 0; r < WN; r++)
                    for (int c = 0; c < WN; c++) begin
                        case (op)
                            0: d[(r*WN+c)*LW +: LW] = src[(r*WN+c)*LW +: LW];
                            1: d[(r*WN+c)*LW +: LW] = src[(c*WN+r)*LW +: LW];
                            2: d[(r*WN+c)*LW +: LW] = fill;
                            default: d[(r*WN+c)*LW +: LW] = (i == j && r == c) ? fill : '0;
                        endcase
                    end
                ex_wd.push_back(d);
            end
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op);
        cmd_src_row = 2'(sr); cmd_src_col = 2'(sc);
        cmd_dst_row = 2'(dr); cmd_dst_col = 2'(dc);
        cmd_rows_m1 = 2'(rm1); cmd_cols_m1 = 2'(cm1); cmd_fill = fill;
        @(posedge clk);
        if (hold_other) begin
            #1;
            cmd_op = 2'((op + 1) % 4); cmd_dst_row = 2'(dr ^ 1); cmd_fill = ~fill;
        end else begin
            #1;
            cmd_valid = 1'b0;
        end
        for (int cyc = 1; cyc <= n + RL + 2; cyc++) begin
            @(negedge clk);
            chk("R9 busy", DW'(busy), DW'(cyc <= n + RL));
            chk("R9 done", DW'(done), DW'(cyc == n + RL + 1));
            chk(reads ? "R3 rd_en" : "R6/R7 no read", DW'(rd_en), DW'(reads && cyc <= n));
            if (reads && cyc <= n) chk("R3 rd_addr", DW'(rd_addr), DW'(ex_rd[cyc-1]));
            chk("R8 wr_en", DW'(wr_en), DW'(cyc > RL && cyc <= n + RL));
            if (cyc > RL && cyc <= n + RL) begin
                chk(op == 1 ? "R5 wr_addr" : "R4 wr_addr", DW'(wr_addr), DW'(ex_wa[cyc-RL-1]));
                case (op)
                    0: chk("R4 copy data", wr_data, ex_wd[cyc-RL-1]);
                    1: chk("R5 transpose data", wr_data, ex_wd[cyc-RL-1]);
                    2: chk("R6 fill data", wr_data, ex_wd[cyc-RL-1]);
                    default: chk("R7 diag data", wr_data, ex_wd[cyc-RL-1]);
                endcase
            end
            if (cyc == n + RL + 1) cmd_valid = 1'b0;  // R2: dropped before the idle edge
        end
    endtask

    initial begin
        #(5.0 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", DW'(busy), '0);
        chk("R1 done", DW'(done), '0);
        chk("R1 rd_en", DW'(rd_en), '0);
        chk("R1 wr_en", DW'(wr_en), '0);
        rst_n = 1'b1;
        @(negedge clk);
        run_cmd(0, 0, 0, 2, 1, 1, 2, 32'h0, 1'b0);         // R4 copy 2x3
        run_cmd(1, 0, 0, 2, 2, 1, 1, 32'h0, 1'b0);         // R5 square transpose
        run_cmd(1, 0, 1, 1, 0, 0, 2, 32'h0, 1'b0);         // R5 1x3 -> 3x1
        run_cmd(2, 0, 0, 0, 0, 1, 1, 32'hDEAD_BEEF, 1'b1); // R6 fill, R2 hold
        run_cmd(3, 0, 0, 1, 1, 2, 2, 32'h3F80_0000, 1'b0); // R7 diagonal 3x3
        run_cmd(0, 3, 3, 0, 0, 0, 0, 32'h0, 1'b0);         // R3 single window
        run_cmd(0, 0, 0, 0, 0, 3, 3, 32'h0, 1'b1);         // R3 full grid in place, R2
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule